// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

This block runs on a bit clock that is phase-locked to an 8 kHz frame strobe. It counts the bit-clock cycles that fit in one frame and decides which supported telephony bit rate is present. From that count it derives a three-bit multiplier code and holds it for a downstream frequency synthesizer. Measurement starts only once the active-low reset is released. The code is latched once per reset, after two full frames in a row give exactly the same length.

A count outside the supported set raises an error flag. An error is also raised when the frame strobe is missing for longer than the counter's saturation limit. After the code is latched, a settle flag rises a fixed number of bit-clock cycles later. This models the time the synthesizer needs to lock onto the new multiplier.

Top module: `frc_ratio_detect`

## Requirements
- R1: While `rst_ni` is low, `mult_code_o`, `valid_o`, `error_o` and `settled_o` are all zero.
- R2: A frame's length is the number of `pclk_i` cycles between two successive rising edges of `fsync_i`. The supported lengths map to these codes: 32→0, 64→1, 96→2, 128→3, 256→5, 512→6, 1024→7.
- R3: Frame lengths of 192 and of 193 cycles both give code 4.
- R4: The cycles before the first frame-strobe rise after reset are never measured. After only two strobe rises (one full frame), `valid_o` stays low.
- R5: The code is latched only when two consecutive full frames have equal lengths. Frames that alternate between 192 and 193 cycles never set `valid_o`.
- R6: A full frame whose length is not supported sets `error_o` and leaves `valid_o` low.
- R7: If no strobe rise arrives within 1100 cycles of the previous one, the counter saturates and `error_o` is set.
- R8: `error_o` and `valid_o` are never high together. A supported frame length clears `error_o`.
- R9: Once `valid_o` is high, `valid_o` and `mult_code_o` stay unchanged until reset, even if the frame length later changes.
- R10: `settled_o` rises exactly 64 `pclk_i` cycles after `valid_o` rises, and it is never high while `valid_o` is low.
- R11: `mult_code_o` is zero whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Bit clock; every register in the block runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | 8 kHz frame strobe, synchronous to `pclk_i` |
| mult_code_o | output | 3 | Latched multiplier code |
| valid_o | output | 1 | The code has been latched |
| error_o | output | 1 | Unsupported or overflowed frame length |
| settled_o | output | 1 | The synthesizer settle delay has elapsed since latching |

## Verification
Some properties are checked on every cycle: outputs are zero during reset, valid and error are never high together, the code is zero until valid, the code does not move once latched, and settle depends on valid with an exact 64-cycle spacing. Other behaviour only shows up in the bench's frame sequences. These are the length-to-code mapping for every supported rate, the merging of 192 and 193, the discarded partial first frame, the rejection of unequal consecutive lengths, the error for unsupported and missing strobes, and the clearing of the error by a good frame.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned MAX_LEN_DEF = 1100;
  localparam int unsigned SETTLE_DEF  = 64;
  localparam int unsigned CODE_W      = 3;
  localparam int unsigned NUM_RATES   = 9;

  // cycles per frame for each supported bit rate, and the code it maps to
  localparam int unsigned RATE_LEN  [NUM_RATES] = '{32, 64, 96, 128, 192, 193, 256, 512, 1024};
  localparam int unsigned RATE_CODE [NUM_RATES] = '{0, 1, 2, 3, 4, 4, 5, 6, 7};
endpackage

// File: rtl/frc_frame_counter.sv
module frc_frame_counter #(
  parameter int unsigned MAX_LEN = 1100,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             frame_stb_o,
  output logic [CNT_W-1:0] frame_len_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_LEN + 1);

  logic             fs_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = fsync_i & ~fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q        <= 1'b1;  // a strobe already high at release is not an edge
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      frame_stb_o <= 1'b0;
      frame_len_o <= '0;
      ovf_o       <= 1'b0;
    end else begin
      fs_q        <= fsync_i;
      frame_stb_o <= 1'b0;
      ovf_o       <= 1'b0;
      if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
        if (armed_q) begin
          frame_stb_o <= 1'b1;
          frame_len_o <= cnt_q;
        end
      end else if (armed_q) begin
        if (cnt_q < SAT_V) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == SAT_V - CNT_W'(1)) ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frc_classifier.sv
module frc_classifier
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic [CNT_W-1:0]  len_i,
  output logic              known_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_RATES-1:0] hit;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_cmp
    assign hit[i] = (len_i == CNT_W'(RATE_LEN[i]));
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit[i]) code_o = code_o | CODE_W'(RATE_CODE[i]);
    end
  end

  assign known_o = |hit;
endmodule

// File: rtl/frc_code_latch.sv
module frc_code_latch
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  logic [CNT_W-1:0]  frame_len_i,
  input  logic              known_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ovf_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              error_o
);
  logic [CNT_W-1:0] prev_len_q;
  logic             prev_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_len_q <= '0;
      prev_ok_q  <= 1'b0;
      code_o     <= '0;
      valid_o    <= 1'b0;
      error_o    <= 1'b0;
    end else if (!valid_o) begin
      if (ovf_i) begin
        error_o   <= 1'b1;
        prev_ok_q <= 1'b0;
      end else if (frame_stb_i) begin
        if (!known_i) begin
          error_o   <= 1'b1;
          prev_ok_q <= 1'b0;
        end else if (prev_ok_q && frame_len_i == prev_len_q) begin
          code_o  <= code_i;
          valid_o <= 1'b1;
          error_o <= 1'b0;
        end else begin
          prev_len_q <= frame_len_i;
          prev_ok_q  <= 1'b1;
          error_o    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/frc_settle_timer.sv
module frc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic settled_o
);
  localparam int unsigned TW = $clog2(SETTLE_CYC + 1);

  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q    <= '0;
      settled_o <= 1'b0;
    end else if (!valid_i) begin
      tcnt_q    <= '0;
      settled_o <= 1'b0;
    end else if (!settled_o) begin
      tcnt_q <= tcnt_q + TW'(1);
      if (tcnt_q == TW'(SETTLE_CYC - 1)) settled_o <= 1'b1;
    end
  end
endmodule

// File: rtl/frc_ratio_detect.sv
module frc_ratio_detect
  import frc_pkg::*;
#(
  parameter int unsigned MAX_LEN    = MAX_LEN_DEF,
  parameter int unsigned SETTLE_CYC = SETTLE_DEF
) (
  input  logic              pclk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  output logic [CODE_W-1:0] mult_code_o,
  output logic              valid_o,
  output logic              error_o,
  output logic              settled_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 2);

  logic              frame_stb;
  logic [CNT_W-1:0]  frame_len;
  logic              ovf;
  logic              known;
  logic [CODE_W-1:0] code;

  frc_frame_counter #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i       (pclk_i),
    .rst_ni      (rst_ni),
    .fsync_i     (fsync_i),
    .frame_stb_o (frame_stb),
    .frame_len_o (frame_len),
    .ovf_o       (ovf)
  );

  frc_classifier #(.CNT_W(CNT_W)) u_cls (
    .len_i   (frame_len),
    .known_o (known),
    .code_o  (code)
  );

  frc_code_latch #(.CNT_W(CNT_W)) u_lat (
    .clk_i       (pclk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb),
    .frame_len_i (frame_len),
    .known_i     (known),
    .code_i      (code),
    .ovf_i       (ovf),
    .code_o      (mult_code_o),
    .valid_o     (valid_o),
    .error_o     (error_o)
  );

  frc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_set (
    .clk_i     (pclk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_o),
    .settled_o (settled_o)
  );
endmodule

// File: rtl/frc_ratio_detect_chk.sv
module frc_ratio_detect_chk #(
  parameter int unsigned SETTLE_CYC = 64
) (
  input logic       pclk_i,
  input logic       rst_ni,
  input logic [2:0] mult_code_o,
  input logic       valid_o,
  input logic       error_o,
  input logic       settled_o
);
  localparam int unsigned VW = $clog2(SETTLE_CYC + 2);
  localparam logic [VW-1:0] VMAX = VW'(SETTLE_CYC + 1);

  logic [VW-1:0] vcnt;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni)              vcnt <= '0;
    else if (!valid_o)        vcnt <= '0;
    else if (vcnt != VMAX)    vcnt <= vcnt + VW'(1);
  end

  // R1
  reset_zero_chk: assert property (@(posedge pclk_i)
    !rst_ni |-> (mult_code_o == 3'd0 && !valid_o && !error_o && !settled_o));

  // R8
  excl_flags_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !(valid_o && error_o));

  // R11
  code_idle_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !valid_o |-> mult_code_o == 3'd0);

  // R9
  code_hold_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o && $stable(mult_code_o)));

  // R10
  settle_dep_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    settled_o |-> valid_o);

  // R10
  settle_delay_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> vcnt == VW'(SETTLE_CYC));

  // R10
  settle_late_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (vcnt > VW'(SETTLE_CYC)) |-> settled_o);
endmodule

bind frc_ratio_detect frc_ratio_detect_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/sim_frc_ratio_detect.sv
module sim_frc_ratio_detect;
  logic       clk   = 1'b0;
  logic       rst_n = 1'b1;
  logic       fsync = 1'b0;
  logic [2:0] code;
  logic       valid, error, settled;

  int n_chk  = 0;
  int n_fail = 0;
  int gap    = -1;
  int vc     = 0;
  bit seen   = 1'b0;

  always #5 clk = ~clk;

  frc_ratio_detect u0 (
    .pclk_i      (clk),
    .rst_ni      (rst_n),
    .fsync_i     (fsync),
    .mult_code_o (code),
    .valid_o     (valid),
    .error_o     (error),
    .settled_o   (settled)
  );

  // cycles from valid rising to settled rising, seen at the ports
  always @(negedge clk) begin
    if (!valid) vc = 0;
    else begin
      if (settled && !seen) begin gap = vc; seen = 1'b1; end
      vc++;
    end
  end

  function automatic int exp_code(int n);
    case (n)
      32: return 0;   64: return 1;   96: return 2;   128: return 3;
      192: return 4;  193: return 4;  256: return 5;  512: return 6;
      1024: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fsync = 1'b0;
    repeat (4) @(negedge clk);
    chk(code == 0 && !valid && !error && !settled, "R1 outputs in reset",
        {code, valid, error, settled}, 0);
    rst_n = 1'b1;
    seen  = 1'b0;
    gap   = -1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frames(int n, int k);
    for (int f = 0; f < k; f++) begin
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      repeat (n - 1) @(negedge clk);
    end
  endtask

  task automatic run_ok(int n, bit full);
    int e = exp_code(n);
    do_reset();
    send_frames(n, 2);
    chk(!valid, "R4 one full frame only", valid, 0);
    send_frames(n, 1);
    chk(valid, "R2 valid after two equal frames", valid, 1);
    if (n == 192 || n == 193) chk(code == e, "R3 merged code", code, e);
    else                      chk(code == e, "R2 code map", code, e);
    chk(!error, "R8 no error on good frames", error, 0);
    send_frames(n, 3);
    chk(settled, "R10 settled", settled, 1);
    chk(gap == 64, "R10 settle delay", gap, 64);
    if (full) begin
      send_frames((n == 32) ? 64 : 32, 3);
      chk(valid && code == e, "R9 code held after rate change", code, e);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    #1 rst_n = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R9 R10: every supported rate
    begin
      int lens [9] = '{32, 64, 96, 128, 192, 193, 256, 512, 1024};
      for (int i = 0; i < 9; i++) run_ok(lens[i], 1'b1);
      // random picks
      for (int i = 0; i < 5; i++) run_ok(lens[$urandom % 9], 1'b0);
    end

    // R5: alternating 192/193 never latches, then a matching pair does (R3)
    do_reset();
    for (int i = 0; i < 3; i++) begin
      send_frames(192, 1);
      send_frames(193, 1);
    end
    chk(!valid, "R5 unequal frames", valid, 0);
    chk(!error, "R5 no error", error, 0);
    send_frames(193, 2);
    chk(valid && code == 4, "R3 193 after alternation", code, 4);

    // R6 R11 R8: unsupported length then recovery
    do_reset();
    send_frames(100, 4);
    chk(error, "R6 error flag", error, 1);
    chk(!valid, "R6 valid low", valid, 0);
    chk(code == 0, "R11 code zero", code, 0);
    send_frames(64, 2);
    chk(!error && !valid, "R8 error cleared", {error, valid}, 0);
    send_frames(64, 1);
    chk(valid && code == 1, "R8 latch after error", code, 1);

    // R7: missing strobe saturates
    do_reset();
    send_frames(32, 1);
    repeat (1200) @(negedge clk);
    chk(error, "R7 overflow error", error, 1);
    chk(!valid, "R7 valid low", valid, 0);

    // R6: random unsupported lengths
    for (int i = 0; i < 4; i++) begin
      int n = 40 + int'($urandom % 900);
      if (exp_code(n) < 0) begin
        do_reset();
        send_frames(n, 3);
        chk(error && !valid, "R6 random unsupported", {error, valid}, 2);
      end
    end

    do_reset();
    chk(code == 0 && !valid, "R1 after release", {code, valid}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule